// File: doc/BRIEF.md
# Packed-Instruction Slot Sequencer

This block steps a small stack processor through program words of 24 bits. Each word carries four 6-bit instruction fields. One fetch slot reads the word at the program counter. Four execute slots then hand the fields out one at a time, starting with the most significant field. The sequencer owns the program counter. It decides when a word ends early and applies branch, call, return and loop-repeat decisions. It also tells the surrounding datapath which stack moves to make, and when an in-line literal is on the fetch bus.

The datapath feeds in several values: the zero status of the data-stack top and the return-stack top, the carry flag, the return-stack top value, and an interrupt request with its vector address. It gets back the current slot, the active opcode, and the decoded I/O-bus access fields. It also gets the program-counter value that will be loaded at the next edge, a fetch request with its address, and one-cycle strobes for return-stack push, pop and decrement and for the data-stack pop. Memory reads are assumed to return data in the same cycle as the request. The interrupt hook is a slot of its own (slot 5) and is flagged on a dedicated output.

Top module: `pkw_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `slot` is 0, `fetch_req` is 1 and `fetch_addr` is 0. Interrupts start out enabled.
- R2: In slot 0 the block requests the word at `fetch_addr` (the PC), captures it, and loads PC+1 (`pc_next = fetch_addr + 1`). The next slot is 1.
- R3: Slots 1, 2, 3 and 4 present word bits 23:18, 17:12, 11:6 and 5:0 on `op`, with `op_valid` high. Slot 4 is followed by slot 0 unless an interrupt is taken. In slots 0 and 5, `op_valid` is low.
- R4: A field with bit 5 set is an I/O-bus access: `io_en` is 1, `io_wr` equals field bit 4 (1 = write) and `io_addr` equals field bits 3:0. A field with bit 5 clear gives `io_en` = 0.
- R5: Codes 0x1E (no-op) and 0x01 (return) end the word in any slot. The next slot is 0, or 5 when taken from slot 4 under R14.
- R6: Codes 0x00 (jump), 0x02 (branch if T zero), 0x03 (branch if carry clear), 0x04 (call) and 0x05 (count loop) act only in slot 1. They always end the word after slot 1. When taken, `pc_next` is {PC[23:18], word[17:0]}. When not taken, PC keeps its incremented value.
- R7: Code 0x02 always asserts `t_pop` and is taken when `t_zero` is 1. Code 0x03 never asserts `t_pop` and is taken when `carry` is 0.
- R8: Code 0x04 asserts `r_push` with `r_push_data` equal to the address of the word after the current one.
- R9: Code 0x01 asserts `r_pop` and sets `pc_next = r_top`, which may leave the page. Code 0x07 does the same and also re-enables interrupts.
- R10: Code 0x05 with `r_zero` = 0 asserts `r_dec` and is taken. With `r_zero` = 1 it asserts `r_pop` and is not taken.
- R11: Code 0x06, in any slot, with `r_zero` = 0 asserts `r_dec`, sets `pc_next` to the address of the current word and ends the word. With `r_zero` = 1 it asserts `r_pop` and execution goes on to the next slot.
- R12: Code 0x0A asserts `lit_take` and `fetch_req` with `fetch_addr` = PC, loads PC+1, and goes on to the next slot.
- R13: Codes 0x00, 0x02, 0x03, 0x04 and 0x05 in slots 2 to 4 have no effect. There is no stack strobe, no PC change, and the sequence continues.
- R14: When slot 4 ends, the block goes to slot 5 if `irq_pend` is 1 and interrupts are enabled (or code 0x07 is in slot 4). In slot 5 it asserts `irq_take` and `r_push` with `r_push_data` = PC, loads `pc_next = irq_vec`, and disables interrupts. Slot 0 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_word | input | 24 | Memory data at `fetch_addr`, valid in the same cycle |
| t_zero | input | 1 | Data-stack top is zero |
| r_zero | input | 1 | Return-stack top is zero |
| carry | input | 1 | Carry flag |
| r_top | input | 24 | Return-stack top value |
| irq_pend | input | 1 | Interrupt request pending |
| irq_vec | input | 24 | Handler address for the pending request |
| slot | output | 3 | Current slot (0 fetch, 1-4 fields, 5 interrupt) |
| op | output | 6 | Active instruction field |
| op_valid | output | 1 | `op` holds a field this cycle |
| io_en | output | 1 | Active field is an I/O-bus access |
| io_wr | output | 1 | I/O access is a write |
| io_addr | output | 4 | I/O-bus address |
| fetch_req | output | 1 | Memory read request |
| fetch_addr | output | 24 | Read address (the PC) |
| lit_take | output | 1 | `fetch_word` is an in-line literal for T |
| pc_next | output | 24 | PC value loaded at the next edge |
| r_push | output | 1 | Push `r_push_data` onto the return stack |
| r_push_data | output | 24 | Return address to push |
| r_pop | output | 1 | Pop the return stack |
| r_dec | output | 1 | Decrement the return-stack top |
| t_pop | output | 1 | Pop the data-stack top |
| irq_take | output | 1 | Interrupt slot in progress |

## Verification
The bench puts branch codes into fields 2 to 4. A decoder that did not gate them by slot would push, pop or jump in the middle of an ordinary word. It runs a repeat word that holds an in-line literal. A design that replayed the captured word instead of refetching it, or that restarted from PC, would fetch from the wrong address on the next pass. It executes a return to a different page and then an in-page jump, which exposes a page field taken from the target instead of from PC. It also checks interrupt masking: no second interrupt slot until the return-from-interrupt code runs, and an immediate interrupt slot when that code sits in the last field. A design with a free-running enable would take nested interrupts, and one with a late enable would add a word of delay.

// File: rtl/pkw_pkg.sv
package pkw_pkg;

    localparam int OP_W      = 6;
    localparam int IO_ADDR_W = 4;

    typedef enum logic [2:0] {
        SL_FETCH = 3'd0,
        SL_F1    = 3'd1,
        SL_F2    = 3'd2,
        SL_F3    = 3'd3,
        SL_F4    = 3'd4,
        SL_IRQ   = 3'd5
    } slot_e;

    typedef enum logic [2:0] {
        PCA_HOLD = 3'd0,
        PCA_INC  = 3'd1,
        PCA_PAGE = 3'd2,
        PCA_RTOP = 3'd3,
        PCA_VEC  = 3'd4,
        PCA_REDO = 3'd5
    } pc_act_e;

    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h00;
    localparam logic [OP_W-1:0] OPC_RET   = 6'h01;
    localparam logic [OP_W-1:0] OPC_JZ    = 6'h02;
    localparam logic [OP_W-1:0] OPC_JNC   = 6'h03;
    localparam logic [OP_W-1:0] OPC_CALL  = 6'h04;
    localparam logic [OP_W-1:0] OPC_LOOP  = 6'h05;
    localparam logic [OP_W-1:0] OPC_REPT  = 6'h06;
    localparam logic [OP_W-1:0] OPC_RTI   = 6'h07;
    localparam logic [OP_W-1:0] OPC_LIT   = 6'h0A;
    localparam logic [OP_W-1:0] OPC_NOP   = 6'h1E;

    // control-flow flags of one field
    typedef struct packed {
        logic jump;
        logic jz;
        logic jnc;
        logic call;
        logic loop;
        logic ret;
        logic rti;
        logic nop;
        logic rept;
        logic lit;
    } flow_ctl_t;

    // I/O-bus part of one field
    typedef struct packed {
        logic                 en;
        logic                 wr;
        logic [IO_ADDR_W-1:0] addr;
    } io_ctl_t;

    function automatic flow_ctl_t decode_flow(input logic [OP_W-1:0] f,
                                              input logic first);
        flow_ctl_t c;
        c = '0;
        if (!f[OP_W-1]) begin
            case (f)
                OPC_JUMP: c.jump = first;
                OPC_JZ:   c.jz   = first;
                OPC_JNC:  c.jnc  = first;
                OPC_CALL: c.call = first;
                OPC_LOOP: c.loop = first;
                OPC_RET:  c.ret  = 1'b1;
                OPC_RTI:  c.rti  = 1'b1;
                OPC_NOP:  c.nop  = 1'b1;
                OPC_REPT: c.rept = 1'b1;
                OPC_LIT:  c.lit  = 1'b1;
                default:  c      = '0;
            endcase
        end
        return c;
    endfunction

    function automatic io_ctl_t decode_io(input logic [OP_W-1:0] f);
        io_ctl_t c;
        c.en   = f[OP_W-1];
        c.wr   = f[OP_W-1] & f[IO_ADDR_W];
        c.addr = f[OP_W-1] ? f[IO_ADDR_W-1:0] : '0;
        return c;
    endfunction

endpackage

// File: rtl/pkw_op_decode.sv
module pkw_op_decode
    import pkw_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] word,
    input  slot_e             slot,
    output logic [OP_W-1:0]   op,
    output logic              op_valid,
    output flow_ctl_t         flow,
    output io_ctl_t           io
);
    localparam int FIELDS = WORD_W / OP_W;

    logic [OP_W-1:0] fld [FIELDS];

    // field 0 is the most significant one and runs first
    for (genvar g = 0; g < FIELDS; g++) begin : g_fld
        assign fld[g] = word[WORD_W-1-g*OP_W -: OP_W];
    end

    always_comb begin
        op       = '0;
        op_valid = 1'b0;
        for (int k = 0; k < FIELDS; k++) begin
            if (slot == slot_e'(k + 1)) begin
                op       = fld[k];
                op_valid = 1'b1;
            end
        end
    end

    assign flow = op_valid ? decode_flow(op, slot == SL_F1) : '0;
    assign io   = op_valid ? decode_io(op) : '0;

endmodule

// File: rtl/pkw_slot_ctrl.sv
module pkw_slot_ctrl
    import pkw_pkg::*;
#(
    parameter int FIELDS = 4
) (
    input  slot_e     slot,
    input  flow_ctl_t flow,
    input  logic      t_zero,
    input  logic      r_zero,
    input  logic      carry,
    input  logic      irq_pend,
    input  logic      irq_en,
    output slot_e     slot_nx,
    output pc_act_e   pc_act,
    output logic      r_push,
    output logic      r_pop,
    output logic      r_dec,
    output logic      t_pop,
    output logic      lit_take,
    output logic      irq_take,
    output logic      ien_set,
    output logic      ien_clr
);
    localparam slot_e LAST = slot_e'(FIELDS);

    logic end_word;

    always_comb begin
        slot_nx  = SL_FETCH;
        pc_act   = PCA_HOLD;
        r_push   = 1'b0;
        r_pop    = 1'b0;
        r_dec    = 1'b0;
        t_pop    = 1'b0;
        lit_take = 1'b0;
        irq_take = 1'b0;
        ien_set  = 1'b0;
        ien_clr  = 1'b0;
        end_word = 1'b0;
        case (slot)
            SL_FETCH: begin
                slot_nx = SL_F1;
                pc_act  = PCA_INC;
            end
            SL_IRQ: begin
                slot_nx  = SL_FETCH;
                pc_act   = PCA_VEC;
                r_push   = 1'b1;
                irq_take = 1'b1;
                ien_clr  = 1'b1;
            end
            default: begin
                if (flow.jump) begin
                    pc_act   = PCA_PAGE;
                    end_word = 1'b1;
                end else if (flow.jz) begin
                    t_pop    = 1'b1;
                    pc_act   = t_zero ? PCA_PAGE : PCA_HOLD;
                    end_word = 1'b1;
                end else if (flow.jnc) begin
                    pc_act   = carry ? PCA_HOLD : PCA_PAGE;
                    end_word = 1'b1;
                end else if (flow.call) begin
                    r_push   = 1'b1;
                    pc_act   = PCA_PAGE;
                    end_word = 1'b1;
                end else if (flow.loop) begin
                    r_dec    = ~r_zero;
                    r_pop    = r_zero;
                    pc_act   = r_zero ? PCA_HOLD : PCA_PAGE;
                    end_word = 1'b1;
                end else if (flow.ret || flow.rti) begin
                    r_pop    = 1'b1;
                    pc_act   = PCA_RTOP;
                    ien_set  = flow.rti;
                    end_word = 1'b1;
                end else if (flow.nop) begin
                    end_word = 1'b1;
                end else if (flow.rept) begin
                    r_dec    = ~r_zero;
                    r_pop    = r_zero;
                    pc_act   = r_zero ? PCA_HOLD : PCA_REDO;
                    end_word = ~r_zero;
                end else if (flow.lit) begin
                    lit_take = 1'b1;
                    pc_act   = PCA_INC;
                end

                if (slot == LAST) begin
                    slot_nx = (irq_pend && (irq_en || flow.rti)) ? SL_IRQ : SL_FETCH;
                end else if (end_word) begin
                    slot_nx = SL_FETCH;
                end else begin
                    slot_nx = slot_e'(slot + 3'd1);
                end
            end
        endcase
    end

endmodule

// File: rtl/pkw_pc_unit.sv
module pkw_pc_unit
    import pkw_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int PAGE_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  pc_act_e           pc_act,
    input  logic              capture,
    input  logic [PAGE_W-1:0] tgt_off,
    input  logic [WORD_W-1:0] r_top,
    input  logic [WORD_W-1:0] irq_vec,
    output logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] pc_nx
);
    logic [WORD_W-1:0] word_addr;

    always_comb begin
        case (pc_act)
            PCA_INC:  pc_nx = pc + WORD_W'(1);
            PCA_PAGE: pc_nx = {pc[WORD_W-1:PAGE_W], tgt_off};
            PCA_RTOP: pc_nx = r_top;
            PCA_VEC:  pc_nx = irq_vec;
            PCA_REDO: pc_nx = word_addr;
            default:  pc_nx = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            word_addr <= '0;
        end else begin
            pc <= pc_nx;
            if (capture) begin
                word_addr <= pc;
            end
        end
    end

endmodule

// File: rtl/pkw_sequencer.sv
module pkw_sequencer
    import pkw_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int PAGE_W = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WORD_W-1:0]    fetch_word,
    input  logic                 t_zero,
    input  logic                 r_zero,
    input  logic                 carry,
    input  logic [WORD_W-1:0]    r_top,
    input  logic                 irq_pend,
    input  logic [WORD_W-1:0]    irq_vec,
    output logic [2:0]           slot,
    output logic [OP_W-1:0]      op,
    output logic                 op_valid,
    output logic                 io_en,
    output logic                 io_wr,
    output logic [IO_ADDR_W-1:0] io_addr,
    output logic                 fetch_req,
    output logic [WORD_W-1:0]    fetch_addr,
    output logic                 lit_take,
    output logic [WORD_W-1:0]    pc_next,
    output logic                 r_push,
    output logic [WORD_W-1:0]    r_push_data,
    output logic                 r_pop,
    output logic                 r_dec,
    output logic                 t_pop,
    output logic                 irq_take
);
    localparam int FIELDS = WORD_W / OP_W;

    slot_e             slot_q;
    slot_e             slot_nx;
    logic [WORD_W-1:0] ir_q;
    logic              ien_q;
    logic              ien_set;
    logic              ien_clr;
    flow_ctl_t         flow;
    io_ctl_t           ioc;
    pc_act_e           pc_act;
    logic [WORD_W-1:0] pc;

    pkw_op_decode #(.WORD_W(WORD_W)) u_dec (
        .word     (ir_q),
        .slot     (slot_q),
        .op       (op),
        .op_valid (op_valid),
        .flow     (flow),
        .io       (ioc)
    );

    pkw_slot_ctrl #(.FIELDS(FIELDS)) u_ctrl (
        .slot     (slot_q),
        .flow     (flow),
        .t_zero   (t_zero),
        .r_zero   (r_zero),
        .carry    (carry),
        .irq_pend (irq_pend),
        .irq_en   (ien_q),
        .slot_nx  (slot_nx),
        .pc_act   (pc_act),
        .r_push   (r_push),
        .r_pop    (r_pop),
        .r_dec    (r_dec),
        .t_pop    (t_pop),
        .lit_take (lit_take),
        .irq_take (irq_take),
        .ien_set  (ien_set),
        .ien_clr  (ien_clr)
    );

    pkw_pc_unit #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .pc_act  (pc_act),
        .capture (slot_q == SL_FETCH),
        .tgt_off (ir_q[PAGE_W-1:0]),
        .r_top   (r_top),
        .irq_vec (irq_vec),
        .pc      (pc),
        .pc_nx   (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SL_FETCH;
            ir_q   <= '0;
            ien_q  <= 1'b1;
        end else begin
            slot_q <= slot_nx;
            if (slot_q == SL_FETCH) begin
                ir_q <= fetch_word;
            end
            if (ien_clr) begin
                ien_q <= 1'b0;
            end else if (ien_set) begin
                ien_q <= 1'b1;
            end
        end
    end

    assign slot        = slot_q;
    assign io_en       = ioc.en;
    assign io_wr       = ioc.wr;
    assign io_addr     = ioc.addr;
    assign fetch_req   = (slot_q == SL_FETCH) | lit_take;
    assign fetch_addr  = pc;
    assign r_push_data = pc;

endmodule

// File: rtl/pkw_sequencer_chk.sv
module pkw_sequencer_chk
    import pkw_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        slot,
    input logic [OP_W-1:0]   op,
    input logic              op_valid,
    input logic              fetch_req,
    input logic [WORD_W-1:0] fetch_addr,
    input logic [WORD_W-1:0] pc_next,
    input logic              lit_take,
    input logic              r_push,
    input logic              r_pop,
    input logic              r_dec,
    input logic              irq_take
);
    assert_slot_range_R3: assert property (@(posedge clk) disable iff (rst)
        slot <= 3'd5);

    assert_fetch_then_f1_R2: assert property (@(posedge clk) disable iff (rst)
        (slot == 3'd0) |=> (slot == 3'd1));

    assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (slot == 3'd0) |-> (fetch_req && pc_next == fetch_addr + WORD_W'(1)));

    assert_last_wraps_R3: assert property (@(posedge clk) disable iff (rst)
        (slot == 3'd4) |=> (slot == 3'd0 || slot == 3'd5));

    assert_nop_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OPC_NOP) |=> (slot == 3'd0 || slot == 3'd5));

    assert_irq_after_last_R14: assert property (@(posedge clk) disable iff (rst)
        (slot == 3'd5) |-> ($past(slot) == 3'd4));

    assert_irq_pushes_R14: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (r_push && slot == 3'd5 && !op_valid));

    assert_lit_fetch_R12: assert property (@(posedge clk) disable iff (rst)
        lit_take |-> (fetch_req && pc_next == fetch_addr + WORD_W'(1)));

    assert_stack_excl_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({r_push, r_pop, r_dec}));

endmodule

bind pkw_sequencer pkw_sequencer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot       (slot),
    .op         (op),
    .op_valid   (op_valid),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .pc_next    (pc_next),
    .lit_take   (lit_take),
    .r_push     (r_push),
    .r_pop      (r_pop),
    .r_dec      (r_dec),
    .irq_take   (irq_take)
);

// File: tb/pkw_sequencer_test.sv
`timescale 1ns/1ps
module pkw_sequencer_test;

    localparam logic [5:0] C_JMP = 6'h00, C_RET = 6'h01, C_JZ = 6'h02, C_JNC = 6'h03,
                           C_CALL = 6'h04, C_LOOP = 6'h05, C_REPT = 6'h06, C_RTI = 6'h07,
                           C_LIT = 6'h0A, C_NOP = 6'h1E, C_DUP = 6'h1A, C_SHL = 6'h11,
                           C_ADD = 6'h17, C_NIP = 6'h0C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] fetch_word;
    logic        t_zero = 1'b0, r_zero = 1'b0, carry = 1'b1, irq_pend = 1'b0;
    logic [23:0] r_top = '0, irq_vec = '0;
    logic [2:0]  slot;
    logic [5:0]  op;
    logic        op_valid, io_en, io_wr, fetch_req, lit_take;
    logic [3:0]  io_addr;
    logic [23:0] fetch_addr, pc_next, r_push_data;
    logic        r_push, r_pop, r_dec, t_pop, irq_take;

    logic [23:0] mem [64];
    int n_chk = 0;
    int n_bad = 0;

    assign fetch_word = mem[fetch_addr[5:0]];

    always #4 clk = ~clk;

    pkw_sequencer uut (
        .clk(clk), .rst(rst), .fetch_word(fetch_word), .t_zero(t_zero), .r_zero(r_zero),
        .carry(carry), .r_top(r_top), .irq_pend(irq_pend), .irq_vec(irq_vec),
        .slot(slot), .op(op), .op_valid(op_valid), .io_en(io_en), .io_wr(io_wr),
        .io_addr(io_addr), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .lit_take(lit_take), .pc_next(pc_next), .r_push(r_push),
        .r_push_data(r_push_data), .r_pop(r_pop), .r_dec(r_dec), .t_pop(t_pop),
        .irq_take(irq_take)
    );

    function automatic logic [23:0] w4(input logic [5:0] a, input logic [5:0] b,
                                       input logic [5:0] c, input logic [5:0] d);
        return {a, b, c, d};
    endfunction

    function automatic logic [23:0] br(input logic [5:0] a, input logic [17:0] tgt);
        return {a, tgt};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) mem[i] = {4{C_NOP}};
    endtask

    task automatic do_reset();
        rst = 1'b1;
        t_zero = 1'b0; r_zero = 1'b0; carry = 1'b1; irq_pend = 1'b0;
        r_top = '0; irq_vec = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic t_plain();
        fill_mem();
        mem[0] = w4(C_SHL, C_ADD, C_DUP, C_NIP);
        rst = 1'b1;
        @(negedge clk); #1;
        chk("R1", "slot in reset", slot, 0);
        do_reset();
        chk("R1", "slot", slot, 0);
        chk("R1", "fetch_req", fetch_req, 1);
        chk("R1", "fetch_addr", fetch_addr, 0);
        chk("R2", "pc_next", pc_next, 1);
        chk("R3", "op_valid in fetch", op_valid, 0);
        cyc();
        chk("R2", "slot after fetch", slot, 1);
        chk("R3", "field1", op, C_SHL);
        chk("R3", "op_valid", op_valid, 1);
        cyc(); chk("R3", "field2", op, C_ADD);
        cyc(); chk("R3", "field3", op, C_DUP);
        cyc(); chk("R3", "field4", op, C_NIP); chk("R3", "slot4", slot, 4);
        cyc();
        chk("R3", "wrap slot", slot, 0);
        chk("R2", "next fetch addr", fetch_addr, 1);
    endtask

    task automatic t_io();
        fill_mem();
        mem[0] = w4(6'h35, 6'h29, C_DUP, C_DUP);
        do_reset();
        cyc();
        chk("R4", "io_en wr", io_en, 1); chk("R4", "io_wr", io_wr, 1); chk("R4", "io_addr", io_addr, 5);
        cyc();
        chk("R4", "io_en rd", io_en, 1); chk("R4", "io_wr rd", io_wr, 0); chk("R4", "io_addr rd", io_addr, 9);
        cyc();
        chk("R4", "io_en off", io_en, 0);
    endtask

    task automatic t_early_end();
        fill_mem();
        mem[0] = w4(C_DUP, C_NOP, C_SHL, C_SHL);
        mem[1] = w4(C_DUP, C_DUP, C_RET, C_SHL);
        do_reset();
        r_top = 24'h000020;
        cyc(); cyc();
        chk("R5", "nop seen", op, C_NOP);
        cyc();
        chk("R5", "nop ends word", slot, 0);
        chk("R5", "fetch after nop", fetch_addr, 1);
        cyc(); cyc(); cyc();
        chk("R9", "ret pops", r_pop, 1);
        chk("R9", "ret pc_next", pc_next, 24'h000020);
        cyc();
        chk("R5", "ret ends word", slot, 0);
        chk("R9", "fetch at return", fetch_addr, 24'h000020);
    endtask

    task automatic t_jump_cond();
        fill_mem();
        mem[0]    = br(C_JMP, 18'h00010);
        mem[16]   = br(C_JZ, 18'h00020);
        mem[32]   = br(C_JZ, 18'h00030);
        mem[33]   = br(C_JNC, 18'h00030);
        mem[34]   = br(C_JNC, 18'h00030);
        do_reset();
        cyc();
        chk("R6", "jump pc_next", pc_next, 24'h10);
        chk("R6", "jump no push", r_push, 0);
        cyc();
        chk("R6", "jump ends word", slot, 0);
        chk("R6", "fetch target", fetch_addr, 24'h10);
        t_zero = 1'b1;
        cyc();
        chk("R7", "jz pops", t_pop, 1);
        chk("R7", "jz taken", pc_next, 24'h20);
        cyc();
        t_zero = 1'b0;
        cyc();
        chk("R7", "jz not-taken pops", t_pop, 1);
        chk("R7", "jz not taken", pc_next, 24'h21);
        cyc();
        chk("R6", "not-taken ends word", slot, 0);
        chk("R6", "not-taken fetch", fetch_addr, 24'h21);
        cyc();
        chk("R7", "jnc no pop", t_pop, 0);
        chk("R7", "jnc carry set", pc_next, 24'h22);
        cyc();
        carry = 1'b0;
        cyc();
        chk("R7", "jnc carry clear", pc_next, 24'h30);
    endtask

    task automatic t_call_loop();
        fill_mem();
        mem[0] = br(C_CALL, 18'h00008);
        mem[8] = br(C_LOOP, 18'h00008);
        do_reset();
        cyc();
        chk("R8", "call push", r_push, 1);
        chk("R8", "call return addr", r_push_data, 1);
        chk("R8", "call target", pc_next, 8);
        cyc(); cyc();
        chk("R10", "loop dec", r_dec, 1);
        chk("R10", "loop no pop", r_pop, 0);
        chk("R10", "loop taken", pc_next, 8);
        cyc(); cyc();
        r_zero = 1'b1;
        #1;
        chk("R10", "loop done pop", r_pop, 1);
        chk("R10", "loop done no dec", r_dec, 0);
        chk("R10", "loop falls through", pc_next, 9);
    endtask

    task automatic t_page();
        fill_mem();
        mem[0]  = w4(C_RET, C_SHL, C_SHL, C_SHL);
        mem[16] = br(C_JMP, 18'h00003);
        do_reset();
        r_top = 24'h050010;
        cyc();
        chk("R9", "long return", pc_next, 24'h050010);
        cyc();
        chk("R9", "fetch other page", fetch_addr, 24'h050010);
        cyc();
        chk("R6", "page kept", pc_next, 24'h040003);
    endtask

    task automatic t_repeat();
        fill_mem();
        mem[0] = w4(C_DUP, C_REPT, C_SHL, C_SHL);
        do_reset();
        cyc(); cyc();
        chk("R11", "repeat dec", r_dec, 1);
        chk("R11", "repeat word addr", pc_next, 0);
        cyc();
        chk("R11", "repeat ends word", slot, 0);
        chk("R11", "refetch addr", fetch_addr, 0);
        cyc(); cyc();
        r_zero = 1'b1;
        #1;
        chk("R11", "repeat done pop", r_pop, 1);
        chk("R11", "repeat done no dec", r_dec, 0);
        cyc();
        chk("R11", "repeat continues", slot, 3);
    endtask

    task automatic t_literal();
        fill_mem();
        mem[0] = w4(C_LIT, C_DUP, C_DUP, C_DUP);
        mem[1] = 24'hABCDEF;
        mem[2] = w4(C_LIT, C_REPT, C_NOP, C_NOP);
        mem[3] = 24'h123456;
        do_reset();
        cyc();
        chk("R12", "lit_take", lit_take, 1);
        chk("R12", "lit fetch_req", fetch_req, 1);
        chk("R12", "lit addr", fetch_addr, 1);
        chk("R12", "lit data", fetch_word, 24'hABCDEF);
        chk("R12", "lit pc_next", pc_next, 2);
        cyc();
        chk("R12", "lit continues", slot, 2);
        cyc(); cyc(); cyc();
        chk("R12", "skip literal", fetch_addr, 2);
        cyc();
        chk("R12", "second lit addr", fetch_addr, 3);
        cyc();
        chk("R11", "repeat after literal", pc_next, 2);
        cyc();
        chk("R11", "refetch word not literal", fetch_addr, 2);
    endtask

    task automatic t_ignored();
        fill_mem();
        mem[0] = w4(C_DUP, C_JMP, C_CALL, C_LOOP);
        do_reset();
        cyc(); cyc();
        chk("R13", "jump code f2", op, C_JMP);
        chk("R13", "f2 pc hold", pc_next, 1);
        chk("R13", "f2 no pop", t_pop, 0);
        cyc();
        chk("R13", "sequence continues", slot, 3);
        chk("R13", "call code no push", r_push, 0);
        cyc();
        chk("R13", "loop code no dec", r_dec, 0);
        chk("R13", "loop code no pop", r_pop, 0);
        cyc();
        chk("R13", "next fetch", fetch_addr, 1);
    endtask

    task automatic t_irq();
        fill_mem();
        mem[0]  = w4(C_DUP, C_DUP, C_DUP, C_DUP);
        mem[48] = w4(C_DUP, C_DUP, C_DUP, C_DUP);
        mem[49] = w4(C_DUP, C_DUP, C_DUP, C_RTI);
        do_reset();
        irq_vec  = 24'h000030;
        r_top    = 24'h000005;
        irq_pend = 1'b1;
        cyc(); cyc(); cyc();
        chk("R14", "no irq mid word", irq_take, 0);
        cyc(); cyc();
        chk("R14", "irq slot", slot, 5);
        chk("R14", "irq_take", irq_take, 1);
        chk("R14", "irq push", r_push, 1);
        chk("R14", "irq push data", r_push_data, 1);
        chk("R14", "irq vector", pc_next, 24'h30);
        cyc();
        chk("R14", "fetch handler", fetch_addr, 24'h30);
        repeat (5) cyc();
        chk("R14", "masked", slot, 0);
        chk("R14", "masked fetch", fetch_addr, 24'h31);
        repeat (4) cyc();
        chk("R9", "rti pops", r_pop, 1);
        chk("R9", "rti pc", pc_next, 5);
        cyc();
        chk("R14", "irq after rti", slot, 5);
        chk("R14", "push return", r_push_data, 5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_plain();
        t_io();
        t_early_end();
        t_jump_cond();
        t_call_loop();
        t_page();
        t_repeat();
        t_literal();
        t_ignored();
        t_irq();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule